// File: doc/BRIEF.md
# Coarse-Fine Timestamp Assembler

This block builds absolute timestamps for a bank of hit channels. One free-running coarse counter, shared by every channel, advances on each master clock. Each channel presents a hit strobe together with a snapshot of a 32-tap delay line. The block filters and encodes that snapshot into a 5-bit interpolation code, then joins the coarse count (upper bits) and the fine code (lower bits) into one stamp. The default stamp is 53 bits wide.

The counter and the delay-line phases run at the same frequency but are not aligned. A hit that lands just after a counter edge would therefore read a count one period too low. The block fixes this without a second, phase-shifted counter. The fine code is decoded first, and a status bit derived from it (code in the first quarter of the period) selects which of two successive counter samples becomes the coarse part. All channels share the single counter.

Each channel delivers its stamp as a one-cycle valid pulse at a fixed latency. A hit that arrives while the channel is still processing an earlier one is discarded and counted.

Top module: `ts_assembler`

## Requirements
- R1: The coarse counter is cleared by reset and advances by one on every clock edge, wrapping modulo 2^CW. The first edge after reset release sees count 0.
- R2: A stamp is {coarse, fine}: the CW coarse bits form the upper part and the FW = log2(TAPS) fine bits form the lower part, for a width of CW+FW.
- R3: The taps are first filtered: f[i] = majority(t[i-1], t[i], t[i+1]), with indices taken modulo TAPS. A falling position j is one where f[j-1 mod TAPS] = 1 and f[j] = 0. The fine code is j when exactly one falling position exists.
- R4: A single flipped tap that lies at least two taps away from both run edges does not change the fine code.
- R5: When the filtered taps hold zero falling positions, or more than one, the channel's error flag is high with its valid pulse. The fine field is then 0 and the coarse part is the uncorrected count.
- R6: Consider a hit accepted at edge e, where the counter value before that edge is C. If its fine code is below TAPS/4, the coarse part is C+1; otherwise it is C.
- R7: A hit accepted at edge e raises the channel's valid for exactly one cycle. Valid rises at edge e+3, and the stamp and error flag are presented in that same cycle.
- R8: A hit at any of the three edges after an accepted hit on the same channel is dropped and produces no stamp. A hit at the fourth edge is accepted.
- R9: Each dropped hit increments that channel's OVW-bit drop counter, which saturates at its all-ones value.
- R10: Synchronous reset clears the counter, all valid flags, stamps, error flags, drop counters and in-flight hits.
- R11: Across channels, stamps of hits ordered by true arrival time are strictly increasing. Here true time is the coarse period the hit belongs to, times TAPS, plus its fine code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| hit | input | N_CH | Per-channel hit strobe, sampled on the clock edge |
| taps | input | N_CH*TAPS | Per-channel delay-line snapshot, channel c in bits [c*TAPS +: TAPS] |
| stamp_vld | output | N_CH | One-cycle stamp valid per channel |
| stamp | output | N_CH*(CW+FW) | Per-channel stamp, channel c in bits [c*(CW+FW) +: CW+FW] |
| fine_err | output | N_CH | Invalid tap pattern flag, qualified by stamp_vld |
| drop_cnt | output | N_CH*OVW | Per-channel saturating count of dropped hits |

## Verification
The fine encoding is exercised with clean half-high patterns at every code, with patterns that carry a bubble deep inside a run, and with all-zero, all-one and multi-edge patterns. Together these separate a correct transition decode from an off-by-one decode, from one with no bubble filter, and from one with no error detection. Codes 0, 1, 30 and 31 placed around counter boundaries, across several channels, show whether the status-driven choice of counter sample keeps the stamps strictly ordered in true time. Bursts on a single channel, a long hammering run and hits near the counter wrap probe the drop window, counter saturation and modulo wrap.

// File: rtl/ts_pkg.sv
package ts_pkg;
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/ts_coarse_counter.sv
module ts_coarse_counter #(
  parameter int CW = 48
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] ONE = 1;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + ONE;
  end

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> cnt == $past(cnt) + ONE);
endmodule

// File: rtl/ts_thermo_decode.sv
module ts_thermo_decode #(
  parameter int TAPS = 32,
  parameter int FW   = $clog2(TAPS)
) (
  input  logic [TAPS-1:0] taps,
  output logic [FW-1:0]   code,
  output logic            err
);
  import ts_pkg::*;

  logic [TAPS-1:0] filt;
  logic [TAPS-1:0] fall;

  for (genvar i = 0; i < TAPS; i++) begin : g_filt
    assign filt[i] = maj3(taps[(i + TAPS - 1) % TAPS], taps[i], taps[(i + 1) % TAPS]);
  end

  for (genvar j = 0; j < TAPS; j++) begin : g_fall
    assign fall[j] = filt[(j + TAPS - 1) % TAPS] & ~filt[j];
  end

  always_comb begin
    code = '0;
    for (int j = TAPS - 1; j >= 0; j--) begin
      if (fall[j]) code = FW'(j);
    end
    err = ($countones(fall) != 1);
    if (err) code = '0;
  end
endmodule

// File: rtl/ts_channel.sv
module ts_channel #(
  parameter int CW   = 48,
  parameter int TAPS = 32,
  parameter int OVW  = 8,
  parameter int FW   = $clog2(TAPS),
  parameter int SW   = CW + FW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hit,
  input  logic [TAPS-1:0] taps,
  input  logic [CW-1:0]   cnt_in,
  output logic            vld,
  output logic [SW-1:0]   stamp,
  output logic            err,
  output logic [OVW-1:0]  ovf
);
  localparam logic [FW-1:0]  QTR   = FW'(TAPS / 4);
  localparam logic [OVW-1:0] OVONE = 1;
  localparam logic [OVW-1:0] OVMAX = '1;

  logic            s1_v, s2_v, s3_v;
  logic [TAPS-1:0] s1_taps;
  logic [CW-1:0]   s1_c, s2_c;
  logic [FW-1:0]   s2_f;
  logic            s2_err, s3_err;
  logic [SW-1:0]   s3_stamp;
  logic [FW-1:0]   dec_code;
  logic            dec_err;
  logic            busy, acc, late;

  assign busy = s1_v | s2_v | s3_v;
  assign acc  = hit & ~busy;
  assign late = ~dec_err & (dec_code < QTR);

  ts_thermo_decode #(.TAPS(TAPS), .FW(FW)) u_dec (
    .taps (s1_taps),
    .code (dec_code),
    .err  (dec_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v     <= 1'b0;
      s2_v     <= 1'b0;
      s3_v     <= 1'b0;
      s1_taps  <= '0;
      s1_c     <= '0;
      s2_c     <= '0;
      s2_f     <= '0;
      s2_err   <= 1'b0;
      s3_err   <= 1'b0;
      s3_stamp <= '0;
      vld      <= 1'b0;
      stamp    <= '0;
      err      <= 1'b0;
      ovf      <= '0;
    end else begin
      s1_v <= acc;
      if (acc) begin
        s1_taps <= taps;
        s1_c    <= cnt_in;
      end
      s2_v <= s1_v;
      if (s1_v) begin
        s2_f   <= dec_code;
        s2_err <= dec_err;
        s2_c   <= late ? cnt_in : s1_c;
      end
      s3_v <= s2_v;
      if (s2_v) begin
        s3_stamp <= {s2_c, s2_f};
        s3_err   <= s2_err;
      end
      vld <= s3_v;
      if (s3_v) begin
        stamp <= s3_stamp;
        err   <= s3_err;
      end
      if (hit && busy && ovf != OVMAX) ovf <= ovf + OVONE;
    end
  end

  // R7
  lat_chk: assert property (@(posedge clk) disable iff (rst)
    acc |-> ##4 vld);
  // R7
  pulse_chk: assert property (@(posedge clk) disable iff (rst)
    vld |=> !vld);
  // R6
  late_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (s2_v && !s2_err && s2_f < QTR) |-> s2_c == $past(cnt_in));
  // R5
  err_fine_chk: assert property (@(posedge clk) disable iff (rst)
    (vld && err) |-> stamp[FW-1:0] == '0);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    ovf == OVMAX |=> ovf == OVMAX);
  // R8
  drop_count_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && busy && ovf != OVMAX) |=> ovf == $past(ovf) + OVONE);
endmodule

// File: rtl/ts_assembler.sv
module ts_assembler #(
  parameter int N_CH = 16,
  parameter int CW   = 48,
  parameter int TAPS = 32,
  parameter int OVW  = 8,
  parameter int FW   = $clog2(TAPS),
  parameter int SW   = CW + FW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CH-1:0]      hit,
  input  logic [N_CH*TAPS-1:0] taps,
  output logic [N_CH-1:0]      stamp_vld,
  output logic [N_CH*SW-1:0]   stamp,
  output logic [N_CH-1:0]      fine_err,
  output logic [N_CH*OVW-1:0]  drop_cnt
);
  logic [CW-1:0] coarse;

  ts_coarse_counter #(.CW(CW)) u_cnt (
    .clk (clk),
    .rst (rst),
    .cnt (coarse)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    ts_channel #(.CW(CW), .TAPS(TAPS), .OVW(OVW), .FW(FW), .SW(SW)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .hit    (hit[c]),
      .taps   (taps[c*TAPS +: TAPS]),
      .cnt_in (coarse),
      .vld    (stamp_vld[c]),
      .stamp  (stamp[c*SW +: SW]),
      .err    (fine_err[c]),
      .ovf    (drop_cnt[c*OVW +: OVW])
    );
  end
endmodule

// File: tb/tb_ts_assembler.sv
module tb_ts_assembler;
  localparam int NCH  = 16;
  localparam int CW   = 12;
  localparam int TAPS = 32;
  localparam int FW   = 5;
  localparam int SW   = CW + FW;
  localparam int OVW  = 8;
  localparam longint CMOD = longint'(1) << CW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0]      hit  = '0;
  logic [NCH*TAPS-1:0] taps = '0;
  logic [NCH-1:0]      stamp_vld;
  logic [NCH*SW-1:0]   stamp;
  logic [NCH-1:0]      fine_err;
  logic [NCH*OVW-1:0]  drop_cnt;

  always #2.5 clk = ~clk;

  ts_assembler #(.N_CH(NCH), .CW(CW), .TAPS(TAPS), .OVW(OVW)) dut (
    .clk(clk), .rst(rst), .hit(hit), .taps(taps),
    .stamp_vld(stamp_vld), .stamp(stamp), .fine_err(fine_err), .drop_cnt(drop_cnt)
  );

  int     nchk = 0, nbad = 0;
  int     done = 0;
  int     due[NCH], busy_until[NCH], ovf_m[NCH], pid[NCH], id_in[NCH], code_in[NCH];
  bit     err_in[NCH], exp_er[NCH];
  string  tag_in[NCH], ptag[NCH];
  longint exp_st[NCH];
  longint obs[64];

  task automatic chk(bit ok, string tag, longint act, longint expv);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [TAPS-1:0] mk_taps(int code, bit bub);
    logic [TAPS-1:0] p = '0;
    for (int k = 1; k <= TAPS / 2; k++) p[(code - k + TAPS) % TAPS] = 1'b1;
    if (bub) p[(code + 8) % TAPS] = ~p[(code + 8) % TAPS];
    return p;
  endfunction

  task automatic put(int ch, int code, bit bub, string tag, int idv);
    hit[ch] = 1'b1;
    taps[ch*TAPS +: TAPS] = mk_taps(code, bub);
    code_in[ch] = code; err_in[ch] = 1'b0; tag_in[ch] = tag; id_in[ch] = idv;
  endtask

  task automatic put_raw(int ch, logic [TAPS-1:0] p, string tag);
    hit[ch] = 1'b1;
    taps[ch*TAPS +: TAPS] = p;
    code_in[ch] = 0; err_in[ch] = 1'b1; tag_in[ch] = tag; id_in[ch] = -1;
  endtask

  task automatic model_clear();
    done = 0;
    for (int c = 0; c < NCH; c++) begin
      due[c] = -1; busy_until[c] = 0; ovf_m[c] = 0; pid[c] = -1;
    end
  endtask

  task automatic tick();
    for (int c = 0; c < NCH; c++) begin
      if (hit[c]) begin
        if (done >= busy_until[c]) begin
          busy_until[c] = done + 4;
          due[c] = done + 4;
          exp_er[c] = err_in[c];
          if (err_in[c]) exp_st[c] = (longint'(done) % CMOD) * TAPS;
          else exp_st[c] = ((longint'(done) + ((code_in[c] < TAPS / 4) ? 1 : 0)) % CMOD) * TAPS
                           + code_in[c];
          ptag[c] = tag_in[c];
          pid[c] = id_in[c];
        end else if (ovf_m[c] < 255) begin
          ovf_m[c]++;
        end
      end
    end
    @(posedge clk);
    done++;
    @(negedge clk);
    hit = '0;
    for (int c = 0; c < NCH; c++) begin
      automatic bit vexp = (due[c] == done);
      automatic longint st = longint'(stamp[c*SW +: SW]);
      chk(stamp_vld[c] == vexp, "R7 valid timing", longint'(stamp_vld[c]), longint'(vexp));
      if (vexp) begin
        chk(st == exp_st[c], ptag[c], st, exp_st[c]);
        chk(fine_err[c] == exp_er[c], exp_er[c] ? "R5 error flag" : ptag[c],
            longint'(fine_err[c]), longint'(exp_er[c]));
        if (pid[c] >= 0) obs[pid[c]] = st;
      end
      chk(int'(drop_cnt[c*OVW +: OVW]) == ovf_m[c], "R8 R9 drop count",
          longint'(drop_cnt[c*OVW +: OVW]), longint'(ovf_m[c]));
    end
  endtask

  task automatic drain();
    repeat (6) tick();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    hit = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      chk(stamp_vld[c] == 1'b0, "R10 reset valid", longint'(stamp_vld[c]), 0);
      chk(stamp[c*SW +: SW] == '0, "R10 reset stamp", longint'(stamp[c*SW +: SW]), 0);
      chk(drop_cnt[c*OVW +: OVW] == '0, "R10 reset drop count", longint'(drop_cnt[c*OVW +: OVW]), 0);
    end
    rst = 1'b0;
    model_clear();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=%0d expected=%0d", done, 0);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    model_clear();
    do_reset();

    // R11: codes 0,1,30,31 around successive counter boundaries, spread over channels
    begin
      int tq[64], tf[64], te[64];
      int codes[4] = '{0, 1, 30, 31};
      for (int i = 0; i < 64; i++) begin
        tq[i] = 10 + i / 4;
        tf[i] = codes[i % 4];
        te[i] = (tf[i] < TAPS / 4) ? tq[i] - 1 : tq[i];
      end
      for (int i = 0; i < 64; i++) obs[i] = -1;
      while (done <= te[63]) begin
        for (int i = 0; i < 64; i++)
          if (te[i] == done) put(i % NCH, tf[i], 1'b0, "R11 R6 boundary stamp", i);
        tick();
      end
      drain();
      for (int i = 1; i < 64; i++)
        chk(obs[i] > obs[i-1], "R11 monotonic", obs[i], obs[i-1] + 1);
    end

    // R3: every code on channel 0
    for (int k = 0; k < TAPS; k++) begin
      put(0, k, 1'b0, "R3 fine code", -1);
      repeat (4) tick();
    end
    // R4: bubble inside a run
    for (int k = 0; k < TAPS; k += 3) begin
      put(1, k, 1'b1, "R4 bubble", -1);
      repeat (4) tick();
    end
    // R5: invalid patterns
    put_raw(2, '0, "R5 all zero");              repeat (4) tick();
    put_raw(2, '1, "R5 all one");               repeat (4) tick();
    put_raw(2, 32'h0F0F_0F0F, "R5 many edges"); repeat (4) tick();
    // R8: hits on consecutive edges, the fifth one lands after the window
    for (int k = 0; k < 5; k++) begin
      put(5, 12, 1'b0, "R8 accepted", -1);
      tick();
    end
    drain();
    // R2 R6: random phases on all channels
    for (int n = 0; n < 300; n++) begin
      for (int c = 0; c < NCH; c++)
        if ($urandom_range(5) == 0) begin
          automatic int cd = $urandom_range(TAPS - 1);
          put(c, cd, 1'b0, (cd < TAPS / 4) ? "R6 corrected stamp" : "R2 stamp", -1);
        end
      tick();
    end
    drain();
    // R9: hammer channel 3 until the drop counter saturates
    for (int n = 0; n < 1100; n++) begin
      put(3, 20, 1'b0, "R2 stamp", -1);
      tick();
    end
    drain();
    chk(int'(drop_cnt[3*OVW +: OVW]) == 255, "R9 saturation", longint'(drop_cnt[3*OVW +: OVW]), 255);
    // R1: hits around the counter wrap
    while (done < 4094) tick();
    put(0, 20, 1'b0, "R1 before wrap", -1); tick();
    put(1, 3, 1'b0, "R1 wrap corrected", -1);
    put(2, 25, 1'b0, "R1 last count", -1);   tick();
    put(3, 5, 1'b0, "R1 after wrap", -1);    tick();
    drain();
    // R10: reset mid-run clears everything; counter restarts at 0
    put(6, 9, 1'b0, "R10 in flight", -1); tick();
    do_reset();
    repeat (3) tick();
    put(6, 2, 1'b0, "R1 R10 restart count", -1); tick();
    drain();

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule